// File: doc/BRIEF.md
# Receiver Reset Sequencer

This block produces the cascaded resets for the four subcomponents of a serial receiver. The tiers are, from top to bottom: PLL, clock-data recovery (CDR), receive datapath, and elastic buffer. A reset request at any tier puts that tier and every tier beneath it into reset. When the request is withdrawn, the block releases those resets one at a time, from the top down. Each tier stays in reset for its own parameterized number of clock cycles. The analog parts are not modelled; a cycle count stands in for each settle time.

A full sequence starts at tier 0. Three events trigger one: the end of power-on reset, the full-reset input, and the PLL-reset input. The power-down input also acts as a tier-0 request while it is high, so its falling edge starts a full sequence. These three inputs are asynchronous and pass through a two-flop synchronizer. The CDR, datapath and buffer requests are synchronous and act on the edge where they are sampled. The `done` output is high only when no sequence is pending or running. The defaults are 9000 + 2000 + 600 + 400 = 12000 cycles, which is 120 µs at 100 MHz.

The state machine has six states:
- `ST_HOLD` holds the resets while any request is high.
- `ST_PLL`, `ST_CDR`, `ST_DP` and `ST_BUF` each time one tier.
- `ST_DONE` is the idle state after a completed sequence.

It has five kinds of transition:
- *request* moves any state to `ST_HOLD` while a request is seen, and records the start tier.
- *launch* moves `ST_HOLD` to the tier state of the recorded start tier once no request is seen.
- *advance* moves a tier state to the next one when that tier's hold count expires.
- *finish* moves `ST_BUF` to `ST_DONE`.
- *idle* keeps `ST_DONE` where it is.

Top module: `rx_reset_sequencer`

## Requirements
- R1: While `rst_n` is low, all four reset outputs are 1 and `done` is 0. On the first clock edge after `rst_n` rises, a full sequence starting at the PLL tier begins.
- R2: The reset outputs are nested, so a tier in reset implies every lower tier is in reset. Releases happen one tier per edge at most, in the order PLL, CDR, datapath, buffer.
- R3: Once a sequence starts at tier t, tier t's reset falls HOLD_t cycles after the start. Each following tier's reset falls its own HOLD cycles after the one above it.
- R4: A synchronous request (`cdr_req`, `dp_req`, `buf_req`) sampled high at an edge does three things after that same edge:
  - it asserts the reset of its tier and of all lower tiers;
  - it leaves the higher tiers' resets unchanged;
  - it drives `done` to 0.
- R5: While any request stays high, the resets stay asserted and nothing is released. Timing of the requested tier begins on the first edge at which no request is seen.
- R6: `full_req` and `pll_req` are two-flop synchronized. A request sampled at edge k reaches the state at edge k+2, and its release takes effect two edges after it is sampled low. Either request starts a full sequence from the PLL tier.
- R7: While `pwr_down` is high (after synchronization), all tiers are held in reset. Its falling edge starts a full sequence.
- R8: `done` rises on the same edge that releases the buffer reset, after the buffer reset has been held for its count. `done` is never 1 while any reset output is 1.
- R9: A request for a tier above the running one restarts the sequence at the requested tier.
- R10: A request for a tier below or equal to the running one restarts the running tier's count from zero. It does not skip that tier or any tier below it.
- R11: When several requests are seen together, the highest tier among them is the start tier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low power-on reset; its release starts a full sequence |
| full_req | input | 1 | Asynchronous full-reset request, active high |
| pll_req | input | 1 | Asynchronous PLL-tier request, active high |
| pwr_down | input | 1 | Asynchronous PLL power-down; held as a full request, its fall starts a sequence |
| cdr_req | input | 1 | Synchronous CDR-tier request, active high |
| dp_req | input | 1 | Synchronous datapath-tier request, active high |
| buf_req | input | 1 | Synchronous buffer-tier request, active high |
| pll_rst | output | 1 | PLL reset (tier 0) |
| cdr_rst | output | 1 | CDR reset (tier 1) |
| dp_rst | output | 1 | Receive datapath reset (tier 2) |
| buf_rst | output | 1 | Elastic buffer reset (tier 3) |
| done | output | 1 | High when no sequence is pending or running |

## Verification
- A synchronous request changes the outputs on the edge that samples it, and an asynchronous one two edges later.
- Timing of a released request begins on the first edge that sees no request; for asynchronous inputs this is two edges after the input falls. Each later release is then due the sum of the hold counts further on.
- For every stimulus, the driver computes the exact edge number of each expected output change. The monitor compares each observed change of the five outputs against that edge number and the expected output pattern, so a release that comes one cycle early or late is reported.
- Preemption tests remove the not-yet-due expectations before queueing the restarted sequence.

// File: rtl/rxrs_pkg.sv
package rxrs_pkg;

    localparam int N_TIER = 4;
    localparam int TIER_W = $clog2(N_TIER + 1);

    typedef logic [TIER_W-1:0] tier_t;

    localparam tier_t TIER_IDLE = tier_t'(N_TIER);

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_PLL,
        ST_CDR,
        ST_DP,
        ST_BUF,
        ST_DONE
    } seq_st_e;

    function automatic seq_st_e tier_to_st(tier_t t);
        case (t)
            tier_t'(0): return ST_PLL;
            tier_t'(1): return ST_CDR;
            tier_t'(2): return ST_DP;
            tier_t'(3): return ST_BUF;
            default:    return ST_DONE;
        endcase
    endfunction

endpackage

// File: rtl/rxrs_sync.sv
module rxrs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [1:0] ff;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= 2'b00;
            else        ff <= {ff[0], d[g]};
        end
        assign q[g] = ff[1];
    end
endmodule

// File: rtl/rxrs_prio.sv
module rxrs_prio #(
    parameter  int N  = 4,
    localparam int IW = $clog2(N + 1)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = IW'(N);
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/rxrs_timer.sv
module rxrs_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] lim,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end

    assign expire = (cnt == lim - 1'b1);
endmodule

// File: rtl/rx_reset_sequencer.sv
module rx_reset_sequencer
    import rxrs_pkg::*;
#(
    parameter int PLL_HOLD = 9000,
    parameter int CDR_HOLD = 2000,
    parameter int DP_HOLD  = 600,
    parameter int BUF_HOLD = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic full_req,
    input  logic pll_req,
    input  logic pwr_down,
    input  logic cdr_req,
    input  logic dp_req,
    input  logic buf_req,
    output logic pll_rst,
    output logic cdr_rst,
    output logic dp_rst,
    output logic buf_rst,
    output logic done
);
    localparam int MAX_AB = (PLL_HOLD > CDR_HOLD) ? PLL_HOLD : CDR_HOLD;
    localparam int MAX_CD = (DP_HOLD > BUF_HOLD) ? DP_HOLD : BUF_HOLD;
    localparam int MAX_H  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W  = $clog2(MAX_H + 1);

    // Asynchronous inputs: {power-down, pll request, full request}
    logic [2:0] async_s;
    rxrs_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pwr_down, pll_req, full_req}),
        .q     (async_s)
    );

    // Request vector, index = tier (0 highest)
    logic [N_TIER-1:0] req_vec;
    logic              req_any;
    tier_t             req_tier;

    assign req_vec = {buf_req, dp_req, cdr_req, |async_s};

    rxrs_prio #(.N(N_TIER)) u_prio (
        .req (req_vec),
        .any (req_any),
        .idx (req_tier)
    );

    seq_st_e          state, nxt;
    tier_t            hold_tier, nxt_hold, act_tier;
    logic             expire, tmr_clr;
    logic [CNT_W-1:0] lim;
    logic [N_TIER-1:0] rst_vec;

    // Tier currently in effect
    always_comb begin
        unique case (state)
            ST_HOLD: act_tier = hold_tier;
            ST_PLL:  act_tier = tier_t'(0);
            ST_CDR:  act_tier = tier_t'(1);
            ST_DP:   act_tier = tier_t'(2);
            ST_BUF:  act_tier = tier_t'(3);
            default: act_tier = TIER_IDLE;
        endcase
    end

    // Hold count of the tier being timed
    always_comb begin
        unique case (state)
            ST_PLL:  lim = CNT_W'(PLL_HOLD);
            ST_CDR:  lim = CNT_W'(CDR_HOLD);
            ST_DP:   lim = CNT_W'(DP_HOLD);
            ST_BUF:  lim = CNT_W'(BUF_HOLD);
            default: lim = CNT_W'(1);
        endcase
    end

    // Next state
    always_comb begin
        nxt      = state;
        nxt_hold = hold_tier;
        if (req_any) begin
            nxt      = ST_HOLD;
            nxt_hold = (req_tier < act_tier) ? req_tier : act_tier;
        end else begin
            unique case (state)
                ST_HOLD: nxt = tier_to_st(hold_tier);
                ST_PLL:  if (expire) nxt = ST_CDR;
                ST_CDR:  if (expire) nxt = ST_DP;
                ST_DP:   if (expire) nxt = ST_BUF;
                ST_BUF:  if (expire) nxt = ST_DONE;
                ST_DONE: nxt = ST_DONE;
                default: nxt = ST_HOLD;
            endcase
        end
    end

    assign tmr_clr = req_any || (nxt != state) || (state == ST_DONE);

    rxrs_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .lim    (lim),
        .expire (expire)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_HOLD;
            hold_tier <= tier_t'(0);
        end else begin
            state     <= nxt;
            hold_tier <= nxt_hold;
        end
    end

    // Outputs
    always_comb begin
        rst_vec = '0;
        done    = 1'b0;
        unique case (state)
            ST_DONE: done = 1'b1;
            ST_HOLD, ST_PLL, ST_CDR, ST_DP, ST_BUF: begin
                for (int i = 0; i < N_TIER; i++) begin
                    rst_vec[i] = (tier_t'(i) >= act_tier);
                end
            end
            default: rst_vec = '1;
        endcase
    end

    assign pll_rst = rst_vec[0];
    assign cdr_rst = rst_vec[1];
    assign dp_rst  = rst_vec[2];
    assign buf_rst = rst_vec[3];
endmodule

// File: rtl/rxrs_chk.sv
module rxrs_chk (
    input logic clk,
    input logic rst_n,
    input logic cdr_req,
    input logic dp_req,
    input logic buf_req,
    input logic pll_rst,
    input logic cdr_rst,
    input logic dp_rst,
    input logic buf_rst,
    input logic done
);
    // R2: resets are nested top-down
    a_r2_nested: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((!pll_rst || cdr_rst) && (!cdr_rst || dp_rst) && (!dp_rst || buf_rst)));

    // R2: at most one tier is released per edge
    a_r2_one_release: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({$fell(pll_rst), $fell(cdr_rst), $fell(dp_rst), $fell(buf_rst)}));

    // R8: done excludes every reset
    a_r8_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(pll_rst || cdr_rst || dp_rst || buf_rst));

    // R8: done rises only after the buffer reset was held
    a_r8_done_after_buf: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(buf_rst));

    // R4: synchronous tier requests act on the next edge
    a_r4_buf_req: assert property (@(posedge clk) disable iff (!rst_n)
        buf_req |=> (buf_rst && !done));

    a_r4_dp_req: assert property (@(posedge clk) disable iff (!rst_n)
        dp_req |=> (dp_rst && buf_rst && !done));

    a_r4_cdr_req: assert property (@(posedge clk) disable iff (!rst_n)
        cdr_req |=> (cdr_rst && dp_rst && buf_rst && !done));

    // R5: a held request keeps every already-asserted reset asserted
    a_r5_hold_buf: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_req && $past(buf_req)) |-> buf_rst);
endmodule

bind rx_reset_sequencer rxrs_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cdr_req (cdr_req),
    .dp_req  (dp_req),
    .buf_req (buf_req),
    .pll_rst (pll_rst),
    .cdr_rst (cdr_rst),
    .dp_rst  (dp_rst),
    .buf_rst (buf_rst),
    .done    (done)
);

// File: tb/sim_rx_reset_sequencer.sv
module sim_rx_reset_sequencer;

    localparam int LIM [4] = '{12, 8, 6, 4};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic full_req = 1'b0, pll_req = 1'b0, pwr_down = 1'b0;
    logic cdr_req = 1'b0, dp_req = 1'b0, buf_req = 1'b0;
    logic pll_rst, cdr_rst, dp_rst, buf_rst, done;

    rx_reset_sequencer #(
        .PLL_HOLD (12),
        .CDR_HOLD (8),
        .DP_HOLD  (6),
        .BUF_HOLD (4)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .full_req (full_req),
        .pll_req  (pll_req),
        .pwr_down (pwr_down),
        .cdr_req  (cdr_req),
        .dp_req   (dp_req),
        .buf_req  (buf_req),
        .pll_rst  (pll_rst),
        .cdr_rst  (cdr_rst),
        .dp_rst   (dp_rst),
        .buf_rst  (buf_rst),
        .done     (done)
    );

    logic [4:0] outs;
    assign outs = {done, buf_rst, dp_rst, cdr_rst, pll_rst};

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errs = 0;
    int checks = 0;

    logic [4:0] q_vec [$];
    int         q_cyc [$];
    string      q_tag [$];
    logic [4:0] exp_popped = 5'b01111;
    logic [4:0] prev = 5'b01111;
    bit         mon_on = 1'b0;

    function automatic logic [4:0] vec_for(int t, bit dn);
        logic [3:0] m;
        if (t >= 4) m = 4'h0;
        else        m = 4'hF << t;
        return {dn, m};
    endfunction

    task automatic check(string tag, logic [4:0] act, logic [4:0] exp, int ac, int ec);
        checks++;
        if (act !== exp || ac != ec) begin
            errs++;
            $display("FAIL %s: got %b at cycle %0d, expected %b at cycle %0d", tag, act, ac, exp, ec);
        end
    endtask

    // Driver side: queue expected output changes for a sequence held at
    // tier t from edge h and timed from edge e
    task automatic push_run(int t, int h, int e, string tag);
        logic [4:0] cur;
        logic [4:0] v;
        int         c;
        while (q_cyc.size() > 0 && q_cyc[$] >= h) begin
            void'(q_vec.pop_back());
            void'(q_cyc.pop_back());
            void'(q_tag.pop_back());
        end
        cur = (q_vec.size() > 0) ? q_vec[$] : exp_popped;
        v = vec_for(t, 1'b0);
        if (v != cur) begin
            q_vec.push_back(v); q_cyc.push_back(h); q_tag.push_back(tag);
        end
        c = e;
        for (int i = t; i < 4; i++) begin
            c += LIM[i];
            q_vec.push_back(vec_for(i + 1, i == 3));
            q_cyc.push_back(c);
            q_tag.push_back(tag);
        end
    endtask

    // m[1]=cdr, m[2]=dp, m[3]=buf; t = expected start tier
    task automatic sync_req(logic [3:1] m, int len, int t, string tag);
        int k;
        @(negedge clk);
        cdr_req = m[1]; dp_req = m[2]; buf_req = m[3];
        k = cyc + 1;
        push_run(t, k, k + len, tag);
        repeat (len) @(negedge clk);
        cdr_req = 1'b0; dp_req = 1'b0; buf_req = 1'b0;
    endtask

    // sel: 0=full_req, 1=pll_req, 2=pwr_down
    task automatic async_req(int sel, int len, string tag);
        int k;
        @(negedge clk);
        case (sel)
            0: full_req = 1'b1;
            1: pll_req  = 1'b1;
            default: pwr_down = 1'b1;
        endcase
        k = cyc + 1;
        push_run(0, k + 2, k + len + 2, tag);
        repeat (len) @(negedge clk);
        full_req = 1'b0; pll_req = 1'b0; pwr_down = 1'b0;
    endtask

    // Monitor: every output change is compared with the next expectation
    always @(negedge clk) begin
        if (mon_on && outs !== prev) begin
            if (q_vec.size() == 0) begin
                checks++;
                errs++;
                $display("FAIL unexpected change: got %b at cycle %0d, expected %b (no change)", outs, cyc, prev);
            end else begin
                logic [4:0] ev;
                int         ec;
                string      et;
                ev = q_vec.pop_front();
                ec = q_cyc.pop_front();
                et = q_tag.pop_front();
                exp_popped = ev;
                check(et, outs, ev, cyc, ec);
            end
            prev = outs;
        end
    end

    initial begin
        int k0;
        repeat (3) @(negedge clk);
        check("R1 reset state", outs, 5'b01111, cyc, cyc);
        prev = outs;
        mon_on = 1'b1;
        rst_n = 1'b1;
        k0 = cyc + 1;
        push_run(0, k0, k0, "R1/R3 power-up sequence");
        repeat (45) @(negedge clk);
        check("R8 idle done", outs, 5'b10000, cyc, cyc);

        sync_req(3'b100, 1, 3, "R4 buffer tier");
        repeat (20) @(negedge clk);
        sync_req(3'b010, 5, 2, "R5 held datapath tier");
        repeat (25) @(negedge clk);
        sync_req(3'b001, 1, 1, "R4/R3 cdr tier");
        repeat (30) @(negedge clk);
        async_req(1, 1, "R6 pll request");
        repeat (40) @(negedge clk);
        async_req(0, 10, "R5/R6 held full request");
        repeat (40) @(negedge clk);
        async_req(2, 15, "R7 power-down fall");
        repeat (40) @(negedge clk);
        sync_req(3'b110, 1, 2, "R11 simultaneous dp+buf");
        repeat (25) @(negedge clk);

        // R9: cdr request while datapath tier is timing
        sync_req(3'b010, 1, 2, "R9 dp run");
        repeat (2) @(negedge clk);
        sync_req(3'b001, 1, 1, "R9 cdr preempts dp");
        repeat (30) @(negedge clk);

        // R10: buffer request while PLL tier is timing restarts PLL tier
        async_req(0, 1, "R10 full run");
        repeat (5) @(negedge clk);
        sync_req(3'b100, 1, 0, "R10 lower request restarts pll");
        repeat (45) @(negedge clk);

        check("R8 final done", outs, 5'b10000, cyc, cyc);
        while (q_vec.size() > 0) begin
            checks++;
            errs++;
            $display("FAIL %s: missing change, got none, expected %b at cycle %0d", q_tag[0], q_vec[0], q_cyc[0]);
            void'(q_vec.pop_front());
            void'(q_cyc.pop_front());
            void'(q_tag.pop_front());
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: got hang, expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule